// File: doc/BRIEF.md
# Register Rename Map with History Rollback

This block maps architectural registers onto a larger pool of physical registers for an out-of-order core. It holds three structures: a map table that gives the current physical register of each architectural register, a free list of physical registers that nothing maps to, and a history log with one entry per destination rename. A rename request for one destination allocates a fresh physical register from the free list and returns it together with the mapping it replaces. Both are written into the history log, tagged with the instruction's sequence number. A request can also be marked as a reuse rename. Such a request keeps the current mapping (the new register equals the previous one), takes nothing from the free list, and is still logged.

Recovery walks the log and restores no checkpoint. A squash with sequence number S removes every log entry younger than S, newest entry first. For each removed entry the previous mapping goes back into the map table, and the register that had been allocated goes back onto the free list. A commit with sequence number C retires every entry at or below C, oldest entry first, and releases the register that the entry superseded. An entry whose new and previous registers are equal frees nothing and restores nothing. Each walk handles one entry per cycle and holds a busy output high until it ends. Source operands are looked up combinationally through a separate read port.

Top module: `renameMapUnit`

## Requirements
- R1: After reset the map table holds the identity mapping (architectural register i maps to physical register i), busy is low, and freeCount equals PHYS_REGS-ARCH_REGS. The free list is ordered ARCH_REGS, ARCH_REGS+1, ... PHYS_REGS-1.
- R2: A granted normal rename returns the register at the head of the free list on renameNewPhys and the current mapping of renameArch on renamePrevPhys. From the next cycle, srcPhys for that architectural register returns the new register.
- R3: A granted reuse rename (renameReuse=1) returns renameNewPhys equal to renamePrevPhys, logs the entry, and leaves freeCount unchanged.
- R4: A rename is refused (renameGrant=0) when the free list is empty and renameReuse=0, or when the history log holds HIST_DEPTH entries. A refused rename changes neither the map nor freeCount.
- R5: A squash with sequence S undoes every logged entry whose sequence is greater than S, newest first. It restores the map entry to the previous register and appends the new register to the free list. Older entries are kept.
- R6: A commit with sequence C retires every logged entry whose sequence is at or below C, oldest first, and appends its previous register to the free list. The map table is not changed.
- R7: An entry whose new and previous registers are equal adds nothing to the free list and changes no map entry, on either squash or commit.
- R8: A walk removes one entry per cycle. busy is high from the cycle after the request until the walk ends, for exactly (entries removed + 1) cycles. Renames are refused while busy is high and in any cycle that carries a squash or commit request.
- R9: A commit request is ignored when it arrives in the same cycle as a squash request or while a squash walk is in progress.
- R10: Freed registers are appended at the tail of the free list, and allocation takes them in first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| renameValid | input | 1 | Rename request for one destination |
| renameReuse | input | 1 | Keep the current mapping instead of allocating |
| renameArch | input | $clog2(ARCH_REGS) | Destination architectural register |
| renameSeq | input | SEQ_W | Sequence number of the renaming instruction |
| renameGrant | output | 1 | Request accepted this cycle |
| renameNewPhys | output | $clog2(PHYS_REGS) | Physical register assigned |
| renamePrevPhys | output | $clog2(PHYS_REGS) | Mapping being replaced |
| srcArch | input | $clog2(ARCH_REGS) | Source lookup address |
| srcPhys | output | $clog2(PHYS_REGS) | Current mapping of srcArch |
| squashValid | input | 1 | Start a squash walk |
| squashSeq | input | SEQ_W | Entries younger than this are undone |
| commitValid | input | 1 | Start a commit walk |
| commitSeq | input | SEQ_W | Entries at or below this are retired |
| busy | output | 1 | A walk is in progress |
| freeCount | output | $clog2(PHYS_REGS+1) | Registers on the free list |

## Verification
The rename path is driven with repeated writes to one architectural register, with writes to different registers, and with reuse requests mixed in. The returned previous mapping shows whether the chain of mappings is kept, and the free count shows whether reuse wrongly consumes a register. Squashes are given thresholds that cut the log in the middle, and commits are given thresholds below, inside and above the logged range. Busy-cycle counts, free counts and a full map sweep afterwards show whether the walk goes in the right direction, stops at the right entry and handles equal-register entries correctly. Draining the free list and then filling the log with reuse renames separates the two refusal causes. A commit that arrives together with a squash, and one that arrives during a squash walk, must leave the log untouched.

// File: rtl/renamePkg.sv
package renamePkg;
  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic doRename;
    logic undoNewest;
    logic retireOldest;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_SQUASH,
    WALK_COMMIT
  } walkState_t;
endpackage

// File: rtl/renameCtrl.sv
module renameCtrl
  import renamePkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renameValid,
  input  logic             renameReuse,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             histEmpty,
  input  logic             histFull,
  input  logic             freeEmpty,
  input  logic [SEQ_W-1:0] newestSeq,
  input  logic [SEQ_W-1:0] oldestSeq,
  output ctrlStrobes_t     strobes,
  output logic             renameGrant,
  output logic             busy
);
  walkState_t       state;
  logic [SEQ_W-1:0] tgtSeq;
  logic             idle;

  assign idle = (state == WALK_IDLE);
  assign busy = !idle;

  always_comb begin
    renameGrant = renameValid && idle && !squashValid && !commitValid &&
                  !histFull && (renameReuse || !freeEmpty);
    strobes.doRename     = renameGrant;
    strobes.undoNewest   = (state == WALK_SQUASH) && !histEmpty && (newestSeq > tgtSeq);
    // a squash request in this cycle suppresses any retirement
    strobes.retireOldest = (state == WALK_COMMIT) && !squashValid && !histEmpty &&
                           (oldestSeq <= tgtSeq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WALK_IDLE;
      tgtSeq <= '0;
    end else if (squashValid && state != WALK_SQUASH) begin
      state  <= WALK_SQUASH;
      tgtSeq <= squashSeq;
    end else if (state == WALK_SQUASH && !strobes.undoNewest) begin
      state <= WALK_IDLE;
    end else if (state == WALK_COMMIT && !strobes.retireOldest) begin
      state <= WALK_IDLE;
    end else if (idle && commitValid) begin
      state  <= WALK_COMMIT;
      tgtSeq <= commitSeq;
    end
  end
endmodule

// File: rtl/renameData.sv
module renameData
  import renamePkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int HIST_DEPTH = 16,
  parameter int SEQ_W      = 8,
  localparam int AW  = $clog2(ARCH_REGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int FCW = $clog2(PHYS_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [AW-1:0]    renameArch,
  input  logic [SEQ_W-1:0] renameSeq,
  input  logic             renameReuse,
  input  logic [AW-1:0]    srcArch,
  output logic [PW-1:0]    srcPhys,
  output logic [PW-1:0]    renameNewPhys,
  output logic [PW-1:0]    renamePrevPhys,
  output logic [FCW-1:0]   freeCount,
  output logic             histEmpty,
  output logic             histFull,
  output logic             freeEmpty,
  output logic [SEQ_W-1:0] newestSeq,
  output logic [SEQ_W-1:0] oldestSeq
);
  localparam int HW        = $clog2(HIST_DEPTH);
  localparam int HCW       = $clog2(HIST_DEPTH + 1);
  localparam int FREE_INIT = PHYS_REGS - ARCH_REGS;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [AW-1:0]    arch;
    logic [PW-1:0]    newPhys;
    logic [PW-1:0]    prevPhys;
  } histEntry_t;

  logic [PW-1:0]  mapTable [ARCH_REGS];
  logic [PW-1:0]  freeMem  [PHYS_REGS];
  logic [PW-1:0]  freeHead, freeTail;
  logic [FCW-1:0] freeCnt;
  histEntry_t     histMem  [HIST_DEPTH];
  logic [HW-1:0]  histHead, histTail, newestIdx;
  logic [HCW-1:0] histCnt;
  histEntry_t     newest, oldest;
  logic           pushEn, popEn, undoRestore;
  logic [PW-1:0]  pushReg;

  function automatic logic [PW-1:0] nextFree(input logic [PW-1:0] p);
    return (p == PW'(PHYS_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [HW-1:0] nextHist(input logic [HW-1:0] p);
    return (p == HW'(HIST_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign newestIdx = (histTail == '0) ? HW'(HIST_DEPTH - 1) : histTail - 1'b1;
  assign newest    = histMem[newestIdx];
  assign oldest    = histMem[histHead];
  assign newestSeq = newest.seq;
  assign oldestSeq = oldest.seq;
  assign histEmpty = (histCnt == '0);
  assign histFull  = (histCnt == HCW'(HIST_DEPTH));
  assign freeEmpty = (freeCnt == '0);
  assign freeCount = freeCnt;

  assign srcPhys        = mapTable[srcArch];
  assign renamePrevPhys = mapTable[renameArch];
  assign renameNewPhys  = renameReuse ? renamePrevPhys : freeMem[freeHead];

  always_comb begin
    undoRestore = strobes.undoNewest && (newest.newPhys != newest.prevPhys);
    pushEn      = 1'b0;
    pushReg     = '0;
    if (undoRestore) begin
      pushEn  = 1'b1;
      pushReg = newest.newPhys;
    end else if (strobes.retireOldest && (oldest.newPhys != oldest.prevPhys)) begin
      pushEn  = 1'b1;
      pushReg = oldest.prevPhys;
    end
    popEn = strobes.doRename && !renameReuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) mapTable[i] <= PW'(i);
      for (int i = 0; i < PHYS_REGS; i++)
        freeMem[i] <= (i < FREE_INIT) ? PW'(i + ARCH_REGS) : '0;
      freeHead <= '0;
      freeTail <= PW'(FREE_INIT);
      freeCnt  <= FCW'(FREE_INIT);
      histHead <= '0;
      histTail <= '0;
      histCnt  <= '0;
    end else begin
      if (strobes.doRename)  mapTable[renameArch]  <= renameNewPhys;
      else if (undoRestore)  mapTable[newest.arch] <= newest.prevPhys;
      if (popEn) freeHead <= nextFree(freeHead);
      if (pushEn) begin
        freeMem[freeTail] <= pushReg;
        freeTail          <= nextFree(freeTail);
      end
      freeCnt <= freeCnt + FCW'(pushEn) - FCW'(popEn);
      if (strobes.doRename) begin
        histTail <= nextHist(histTail);
        histCnt  <= histCnt + 1'b1;
      end else if (strobes.undoNewest) begin
        histTail <= newestIdx;
        histCnt  <= histCnt - 1'b1;
      end else if (strobes.retireOldest) begin
        histHead <= nextHist(histHead);
        histCnt  <= histCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.doRename)
      histMem[histTail] <= '{seq: renameSeq, arch: renameArch,
                             newPhys: renameNewPhys, prevPhys: renamePrevPhys};
  end
endmodule

// File: rtl/renameMapUnit.sv
module renameMapUnit
  import renamePkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int HIST_DEPTH = 16,
  parameter int SEQ_W      = 8,
  localparam int AW  = $clog2(ARCH_REGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int FCW = $clog2(PHYS_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renameValid,
  input  logic             renameReuse,
  input  logic [AW-1:0]    renameArch,
  input  logic [SEQ_W-1:0] renameSeq,
  output logic             renameGrant,
  output logic [PW-1:0]    renameNewPhys,
  output logic [PW-1:0]    renamePrevPhys,
  input  logic [AW-1:0]    srcArch,
  output logic [PW-1:0]    srcPhys,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  output logic             busy,
  output logic [FCW-1:0]   freeCount
);
  ctrlStrobes_t     strobes;
  logic             histEmpty, histFull, freeEmpty;
  logic [SEQ_W-1:0] newestSeq, oldestSeq;

  renameCtrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .renameValid(renameValid), .renameReuse(renameReuse),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .histEmpty(histEmpty), .histFull(histFull), .freeEmpty(freeEmpty),
    .newestSeq(newestSeq), .oldestSeq(oldestSeq),
    .strobes(strobes), .renameGrant(renameGrant), .busy(busy)
  );

  renameData #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS),
    .HIST_DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .renameArch(renameArch), .renameSeq(renameSeq), .renameReuse(renameReuse),
    .srcArch(srcArch), .srcPhys(srcPhys),
    .renameNewPhys(renameNewPhys), .renamePrevPhys(renamePrevPhys),
    .freeCount(freeCount), .histEmpty(histEmpty), .histFull(histFull),
    .freeEmpty(freeEmpty), .newestSeq(newestSeq), .oldestSeq(oldestSeq)
  );
endmodule

// File: rtl/renameMapChecker.sv
module renameMapChecker #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int FCW = $clog2(PHYS_REGS + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           renameValid,
  input logic           renameReuse,
  input logic           renameGrant,
  input logic [PW-1:0]  renameNewPhys,
  input logic [PW-1:0]  renamePrevPhys,
  input logic           busy,
  input logic [FCW-1:0] freeCount
);
  assert_free_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    freeCount <= FCW'(PHYS_REGS - ARCH_REGS));

  assert_fresh_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    renameGrant && !renameReuse |-> renameNewPhys != renamePrevPhys);

  assert_alloc_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    renameGrant && !renameReuse |=> freeCount == $past(freeCount) - 1'b1);

  assert_reuse_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    renameGrant && renameReuse |-> renameNewPhys == renamePrevPhys);

  assert_reuse_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    renameGrant && renameReuse |=> $stable(freeCount));

  assert_empty_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    renameValid && !renameReuse && freeCount == '0 |-> !renameGrant);

  assert_walk_nondec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> freeCount >= $past(freeCount));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !renameGrant);
endmodule

bind renameMapUnit renameMapChecker #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_checker (
  .clk(clk), .rst_n(rst_n), .renameValid(renameValid), .renameReuse(renameReuse),
  .renameGrant(renameGrant), .renameNewPhys(renameNewPhys),
  .renamePrevPhys(renamePrevPhys), .busy(busy), .freeCount(freeCount)
);

// File: tb/test_renameMapUnit.sv
`timescale 1ns/1ps
module test_renameMapUnit;
  localparam int ARCH = 8, PHYS = 16, HIST = 16, SEQ_W = 8;

  logic clk = 0, rst_n = 0;
  logic renameValid = 0, renameReuse = 0;
  logic [2:0] renameArch = 0, srcArch = 0;
  logic [SEQ_W-1:0] renameSeq = 0, squashSeq = 0, commitSeq = 0;
  logic squashValid = 0, commitValid = 0;
  logic renameGrant, busy;
  logic [3:0] renameNewPhys, renamePrevPhys, srcPhys;
  logic [4:0] freeCount;

  renameMapUnit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .HIST_DEPTH(HIST), .SEQ_W(SEQ_W)) i_renameMapUnit (
    .clk(clk), .rst_n(rst_n), .renameValid(renameValid), .renameReuse(renameReuse),
    .renameArch(renameArch), .renameSeq(renameSeq), .renameGrant(renameGrant),
    .renameNewPhys(renameNewPhys), .renamePrevPhys(renamePrevPhys),
    .srcArch(srcArch), .srcPhys(srcPhys), .squashValid(squashValid),
    .squashSeq(squashSeq), .commitValid(commitValid), .commitSeq(commitSeq),
    .busy(busy), .freeCount(freeCount)
  );

  always #5 clk = ~clk;

  // reference model
  typedef struct { int seq; int arch; int np; int pp; } hent_t;
  typedef struct { bit g; int np; int pp; string tag; } exp_t;
  int mapM [ARCH];
  int freeQ [$];
  hent_t histQ [$];
  exp_t expQ [$];
  int nChecks = 0, nFail = 0, seqCtr = 1;
  bit finished = 0;
  event sampleEv;

  task automatic chk(bit ok, string tag, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: compares design outputs with the queued expectation
  initial forever begin
    exp_t e;
    @(sampleEv);
    e = expQ.pop_front();
    chk(renameGrant == e.g, {e.tag, " grant"}, renameGrant, e.g);
    if (e.g) begin
      chk(renameNewPhys == e.np, {e.tag, " newPhys"}, renameNewPhys, e.np);
      chk(renamePrevPhys == e.pp, {e.tag, " prevPhys"}, renamePrevPhys, e.pp);
    end
  end

  // driver: one rename request, expectation pushed for the monitor
  task automatic doRename(int arch, bit reuse, string tag);
    exp_t e;
    @(negedge clk);
    renameValid = 1; renameReuse = reuse; renameArch = 3'(arch);
    renameSeq = SEQ_W'(seqCtr);
    e.g = (histQ.size() < HIST) && (reuse || freeQ.size() > 0);
    e.pp = mapM[arch];
    e.np = reuse ? e.pp : ((freeQ.size() > 0) ? freeQ[0] : 0);
    e.tag = tag;
    expQ.push_back(e);
    #2 ->sampleEv;
    @(posedge clk);
    if (e.g) begin
      if (!reuse) void'(freeQ.pop_front());
      mapM[arch] = e.np;
      histQ.push_back('{seqCtr, arch, e.np, e.pp});
      seqCtr++;
    end
    #1 renameValid = 0; renameReuse = 0;
  endtask

  task automatic checkMap(string tag);
    for (int a = 0; a < ARCH; a++) begin
      @(negedge clk);
      srcArch = 3'(a);
      #1 chk(srcPhys == 4'(mapM[a]), tag, srcPhys, mapM[a]);
    end
    @(negedge clk);
    chk(freeCount == 5'(freeQ.size()), {tag, " freeCount"}, freeCount, freeQ.size());
  endtask

  // squash (sq=1) or commit (sq=0); sameCommit/lateCommit add ignored commits (R9)
  task automatic doWalk(bit sq, int seq, bit sameCommit, bit lateCommit, bit probe, string tag);
    int n = 0, cyc = 0;
    @(negedge clk);
    squashValid = sq; squashSeq = SEQ_W'(seq);
    commitValid = !sq || sameCommit; commitSeq = SEQ_W'(sq ? 255 : seq);
    @(posedge clk);
    #1 squashValid = 0; commitValid = 0;
    if (sq) begin
      while (histQ.size() > 0 && histQ[histQ.size()-1].seq > seq) begin
        hent_t h = histQ.pop_back();
        if (h.np != h.pp) begin mapM[h.arch] = h.pp; freeQ.push_back(h.np); end
        n++;
      end
    end else begin
      while (histQ.size() > 0 && histQ[0].seq <= seq) begin
        hent_t h = histQ.pop_front();
        if (h.np != h.pp) freeQ.push_back(h.pp);
        n++;
      end
    end
    @(negedge clk);
    while (busy) begin
      cyc++;
      if (cyc == 1 && lateCommit) begin commitValid = 1; commitSeq = 8'd255; end
      else commitValid = 0;
      if (cyc == 1 && probe) begin
        renameValid = 1; renameReuse = 1;
        #1 chk(renameGrant == 0, "R8 rename while busy", renameGrant, 0);
        renameValid = 0; renameReuse = 0;
      end
      @(negedge clk);
    end
    commitValid = 0;
    chk(cyc == n + 1, {tag, " R8 busy cycles"}, cyc, n + 1);
    checkMap(tag);
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < ARCH; a++) mapM[a] = a;
    for (int p = ARCH; p < PHYS; p++) freeQ.push_back(p);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    checkMap("R1 reset map");

    // R2, R3: chained renames of one register, others, reuse
    doRename(3, 0, "R2 first a3");
    doRename(3, 0, "R2 second a3");
    doRename(5, 0, "R2 a5");
    doRename(1, 1, "R3 reuse a1");
    doRename(2, 0, "R2 a2");
    checkMap("R2 map after renames");

    // R5, R7: squash cuts mid-log, includes a reuse entry
    doWalk(1, 2, 0, 0, 0, "R5 squash 2");
    // R6: commit retires the oldest entry only
    doWalk(0, 1, 0, 0, 0, "R6 commit 1");
    // R10: freed registers come back in FIFO order
    doRename(4, 0, "R10 realloc a4");
    doRename(0, 1, "R7 reuse a0");
    doRename(6, 0, "R10 realloc a6");
    // R6, R7: commit covering a reuse entry
    doWalk(0, seqCtr - 2, 0, 0, 0, "R7 commit reuse");
    // R6: commit below the oldest removes nothing
    doWalk(0, 0, 0, 0, 0, "R6 commit none");

    // R4: drain the free list
    while (freeQ.size() > 0) doRename(seqCtr % ARCH, 0, "R4 drain");
    doRename(7, 0, "R4 refuse empty");
    doRename(7, 1, "R3 reuse on empty");
    checkMap("R4 after refusal");
    // R4: fill the history log
    while (histQ.size() < HIST) doRename(seqCtr % ARCH, 1, "R4 fill");
    doRename(2, 1, "R4 refuse full");
    checkMap("R4 full");

    // R9: commits with and during a squash are ignored; R8 probe
    doWalk(1, seqCtr - 4, 1, 1, 1, "R9 squash with commits");
    doWalk(0, 255, 0, 0, 0, "R6 commit all");
    doRename(5, 0, "R10 after drain");
    checkMap("final");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule